// File: doc/BRIEF.md
# Self-Repairing Cellular Seconds-Minutes Counter

This block counts seconds and minutes from 00:00 up to 59:59 and then wraps to 00:00, a modulo-3600 count. It is built as a row of identical digit cells. Each cell holds one 4-bit digit. Each cell works out its role from a coordinate, which is the number of healthy cells to its left. A small shared genome turns that coordinate into a counting modulus. Cells pass a digit bus and a carry bit to the neighbour on their right.

The row has one cell for each displayed digit plus a few spare cells. When a bit of the fault mask marks a cell, that cell is retired and bypassed. Each cell to its right loads the digit of its left healthy neighbour, so every function moves one place to the right. At the same edge the coordinates are recomputed, so the cells take on their new functions and the displayed time does not change. A tick that arrives during a repair cycle is held for one cycle and then applied. When more cells have been retired than there are spares, an error flag goes high and stays high.

The tick, the fault mask and the error flag are plain control pins. The digit outputs are a continuous view of the count. The block has no streaming interface, so there are no valid/ready rules.

Top module: `cellwatch`

## Requirements
- R1: After reset, all digits read zero, the error flag is low and every cell is healthy.
- R2: A one-cycle pulse on `tick` advances the count at the next clock edge. The output fields are `digits[3:0]` for seconds units (modulo 10), `[7:4]` for seconds tens (modulo 6), `[11:8]` for minutes units (modulo 10) and `[15:12]` for minutes tens (modulo 6). Each field carries into the next, and 59:59 wraps to 00:00.
- R3: A healthy cell's coordinate is the count of healthy cells to its left. Coordinate 0 counts seconds units, 1 seconds tens, 2 minutes units and 3 minutes tens. Coordinates 4 and above are idle spares. After any repair the count keeps advancing correctly.
- R4: A cell marked in `fault_mask` is retired at the next edge. Every healthy cell to its right loads the digit from its nearest healthy left neighbour, and the displayed digits do not change. This also holds when the marked cell is a spare.
- R5: At most one cell is retired per clock cycle, the lowest-indexed pending one first. Several cells marked at the same time are retired over consecutive cycles, and the count is kept at each step.
- R6: Retirement is permanent. Clearing a bit of `fault_mask` has no effect on a cell that has already been retired.
- R7: A tick that arrives in a cycle where a retirement takes place is not lost. It is applied one cycle later.
- R8: `spares_out` rises once the number of retired cells exceeds the number of spares, and it stays high until reset.
- R9: Every cell that has a counting function holds a digit below its modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse that advances the count by one second |
| fault_mask | input | NUM_FUNC+NUM_SPARE (6) | One bit per physical cell; a set bit marks the cell faulty |
| digits | output | 4*NUM_FUNC (16) | Count in BCD, seconds units in the lowest nibble |
| spares_out | output | 1 | Sticky flag: more cells retired than spares exist |

## Verification
The assertions assume that each tick is a single-cycle pulse and that ticks are at least two cycles apart. Under that assumption a deferred tick is always served before the next tick arrives. The rule that a repair keeps the displayed count is only claimed while a spare is still available to absorb the retirement. The bench drives ticks as pulses one cycle wide, with at least one idle cycle between them. It changes `fault_mask` and `tick` only at the falling edge of the clock. It marks several cells at once only when enough spares remain, or when the test is meant to exhaust them.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;

  // Genome: coordinate -> counting modulus; zero means idle spare.
  function automatic digit_t genome_mod(input int unsigned coord, input int unsigned nfunc);
    if (coord >= nfunc) return digit_t'(0);
    return coord[0] ? digit_t'(6) : digit_t'(10);
  endfunction
endpackage

// File: rtl/cw_retire.sv
module cw_retire #(
  parameter int N  = 6,
  parameter int KW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] mask,
  output logic [N-1:0] dead_q,
  output logic [N-1:0] pick,
  output logic         repair_go,
  output logic [KW-1:0] ndead_q
);
  logic [N-1:0] pending;

  always_comb begin
    pending   = mask & ~dead_q;
    pick      = pending & (~pending + N'(1));
    repair_go = |pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dead_q  <= '0;
      ndead_q <= '0;
    end else if (repair_go) begin
      dead_q  <= dead_q | pick;
      ndead_q <= ndead_q + 1'b1;
    end
  end

  assert_retire_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((dead_q & $past(dead_q)) == $past(dead_q)));

  assert_one_retire_per_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones(dead_q ^ $past(dead_q)) <= 1));

  assert_lowest_pending_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    repair_go |=> ((dead_q & ~$past(dead_q)) == ($past(dead_q | mask) & ~$past(dead_q)
                   & ~(($past(dead_q | mask) & ~$past(dead_q)) - N'(1)))));

  assert_count_tracks_retired_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> ($countones(dead_q) == int'(ndead_q)));
endmodule

// File: rtl/cw_coord.sv
module cw_coord #(
  parameter int N  = 6,
  parameter int CW = 3
) (
  input  logic [N-1:0]    dead,
  output logic [N*CW-1:0] coord_flat
);
  logic [CW-1:0] run;

  always_comb begin
    run = '0;
    for (int i = 0; i < N; i++) begin
      coord_flat[i*CW +: CW] = run;
      if (!dead[i]) run = run + 1'b1;
    end
  end
endmodule

// File: rtl/cw_cell.sv
module cw_cell
  import cw_pkg::*;
#(
  parameter int CW = 3,
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] coord,
  input  logic          dead,
  input  logic          shift_en,
  input  digit_t        bus_in,
  input  logic          carry_in,
  output digit_t        bus_out,
  output logic          carry_out,
  output digit_t        digit_q
);
  digit_t modv;
  logic   active, at_top;

  always_comb begin
    modv      = genome_mod(32'(coord), NF);
    active    = !dead && (modv != '0);
    at_top    = (digit_q == modv - 1'b1);
    carry_out = dead ? carry_in : (active && carry_in && at_top);
    bus_out   = dead ? bus_in : digit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  digit_q <= '0;
    else if (shift_en && !dead)  digit_q <= bus_in;
    else if (active && carry_in) digit_q <= at_top ? '0 : digit_q + 1'b1;
  end

  assert_digit_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (digit_q < modv));
endmodule

// File: rtl/cellwatch.sv
module cellwatch
  import cw_pkg::*;
#(
  parameter int NUM_FUNC  = 4,
  parameter int NUM_SPARE = 2,
  localparam int NCELLS   = NUM_FUNC + NUM_SPARE
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic [NCELLS-1:0]           fault_mask,
  output logic [NUM_FUNC*DIGIT_W-1:0] digits,
  output logic                        spares_out
);
  localparam int CW = $clog2(NCELLS + 1);

  logic [NCELLS-1:0]    dead_q, pick, below;
  logic                 repair_go;
  logic [CW-1:0]        ndead_q;
  logic [NCELLS*CW-1:0] coord_flat;
  digit_t               bus   [NCELLS+1];
  logic [NCELLS:0]      carry;
  digit_t               cell_digit [NCELLS];
  logic                 tick_pend_q, tick_go;
  logic                 unused_bus_tail;

  cw_retire #(.N(NCELLS), .KW(CW)) u_retire (
    .clk(clk), .rst_n(rst_n), .mask(fault_mask), .dead_q(dead_q),
    .pick(pick), .repair_go(repair_go), .ndead_q(ndead_q)
  );

  cw_coord #(.N(NCELLS), .CW(CW)) u_coord (.dead(dead_q), .coord_flat(coord_flat));

  // Deferred tick: a repair cycle owns the array, the tick waits one cycle.
  always_comb tick_go = (tick | tick_pend_q) & ~repair_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_pend_q <= 1'b0;
    else        tick_pend_q <= (tick | tick_pend_q) & repair_go;
  end

  // Cells right of the cell being retired shift their function rightward.
  always_comb begin
    below[0] = 1'b0;
    for (int i = 1; i < NCELLS; i++) below[i] = below[i-1] | pick[i-1];
  end

  assign bus[0]   = '0;
  assign carry[0] = tick_go;

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    cw_cell #(.CW(CW), .NF(NUM_FUNC)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .coord(coord_flat[i*CW +: CW]), .dead(dead_q[i]), .shift_en(below[i]),
      .bus_in(bus[i]), .carry_in(carry[i]),
      .bus_out(bus[i+1]), .carry_out(carry[i+1]), .digit_q(cell_digit[i])
    );
  end

  assign unused_bus_tail = ^bus[NCELLS];

  always_comb begin
    digits = '0;
    for (int k = 0; k < NUM_FUNC; k++)
      for (int i = 0; i < NCELLS; i++)
        if (!dead_q[i] && coord_flat[i*CW +: CW] == CW'(k))
          digits[k*DIGIT_W +: DIGIT_W] = cell_digit[i];
  end

  assign spares_out = int'(ndead_q) > NUM_SPARE;

  assert_units_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && !spares_out) |=> (digits[DIGIT_W-1:0] ==
      (($past(digits[DIGIT_W-1:0]) == digit_t'(9)) ? '0 : $past(digits[DIGIT_W-1:0]) + 1'b1)));

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    carry[NCELLS] |=> (digits == '0));

  assert_repair_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (repair_go && (int'(ndead_q) < NUM_SPARE)) |=> $stable(digits));

  assert_tick_deferred_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && repair_go) |=> tick_pend_q);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spares_out |=> spares_out);
endmodule

// File: tb/sim_cellwatch.sv
module sim_cellwatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [5:0]  fault_mask = '0;
  logic [15:0] digits;
  logic        spares_out;
  int          checks = 0;
  int          errors = 0;
  int          n = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cellwatch u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .fault_mask(fault_mask),
                .digits(digits), .spares_out(spares_out));

  function automatic logic [15:0] expect_digits(input int v);
    int s, m;
    s = v % 60;
    m = (v / 60) % 60;
    return {4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_count(input string req);
    check(digits == expect_digits(n), req, digits, expect_digits(n));
  endtask

  task automatic check_flag(input string req, input logic e);
    check(spares_out == e, req, {15'b0, spares_out}, {15'b0, e});
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    n++;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; fault_mask = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; n = 0;
    @(negedge clk);
    check_count("R1 digits zero");
    check_flag("R1 flag low", 1'b0);
  endtask

  task automatic t_carry_chain();
    repeat (9) pulse_tick();
    check_count("R2 units at 9");
    pulse_tick();
    check_count("R2 units carry to tens");
    repeat (49) pulse_tick();
    check_count("R2 at 00:59");
    pulse_tick();
    check_count("R2 seconds carry to minutes");
  endtask

  task automatic t_full_wrap();
    while (n < 3599) pulse_tick();
    check_count("R2 at 59:59");
    pulse_tick();
    n = 0;
    check_count("R2 wrap to 00:00");
  endtask

  task automatic t_bypass_middle();
    repeat (83) pulse_tick();
    @(negedge clk) fault_mask[2] = 1'b1;
    @(negedge clk);
    check_count("R4 count kept across bypass");
    check_flag("R4 flag low", 1'b0);
    for (int i = 0; i < 70; i++) begin
      pulse_tick();
      check_count("R3 reconfigured cells count");
    end
  endtask

  task automatic t_tick_in_repair();
    @(negedge clk) begin fault_mask[0] = 1'b1; tick = 1'b1; end
    @(negedge clk) tick = 1'b0;
    check_count("R7 tick held in repair cycle");
    @(negedge clk);
    n++;
    check_count("R7 held tick applied");
    check_flag("R8 no error with spares used", 1'b0);
  endtask

  task automatic t_exhaust();
    @(negedge clk) fault_mask = '0;
    repeat (2) @(negedge clk);
    check_flag("R6 cleared mask keeps state", 1'b0);
    fault_mask[5] = 1'b1;
    @(negedge clk);
    check_flag("R8 flag on third retirement", 1'b1);
    fault_mask = '0;
    repeat (3) @(negedge clk);
    check_flag("R6 retirement permanent", 1'b1);
  endtask

  task automatic t_pair_at_once();
    t_reset();
    repeat (125) pulse_tick();
    @(negedge clk) fault_mask = 6'b001001;
    @(negedge clk);
    check_count("R5 first of pair retired");
    @(negedge clk);
    check_count("R5 second of pair retired");
    check_flag("R5 flag low", 1'b0);
    for (int i = 0; i < 60; i++) begin
      pulse_tick();
      check_count("R5 count after paired repair");
    end
  endtask

  task automatic t_spare_fault();
    t_reset();
    repeat (7) pulse_tick();
    @(negedge clk) fault_mask[4] = 1'b1;
    @(negedge clk);
    check_count("R4 spare retired, count kept");
    repeat (5) pulse_tick();
    check_count("R4 counting after spare loss");
  endtask

  initial begin
    t_reset();
    t_carry_chain();
    t_full_wrap();
    t_bypass_middle();
    t_tick_in_repair();
    t_exhaust();
    t_pair_at_once();
    t_spare_fault();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule